// File: doc/BRIEF.md
# Masked Sticky-Pending Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines for a small soft processor and presents them as one interrupt request. Each line first passes through a two-flop synchroniser. Any line that is active sets its bit in a pending register. That bit stays set after the line drops, until software acknowledges it. A mask register selects which pending bits may raise the request. The request is registered, and it is high whenever a pending bit and its mask bit are both set.

Software uses a plain synchronous register port. A write strobe carries an address and data. A read strobe returns data one cycle later. Through this port software reads and replaces the mask, reads the pending bits, and clears pending bits by writing ones. It can also read the synchronised line levels and a per-line event counter. Each counter records how many times its line has gone from inactive to active, which helps with diagnostics.

Top module: `sticky_irq_ctrl`

## Requirements
- R1: After reset, the mask (word 0x00), the pending bits (word 0x01), the line state (word 0x02), every counter (words 0x20 to 0x3F) and `cpuIrq` all read as zero.
- R2: A line that is active for at least one synchronised cycle sets its pending bit. The bit stays set after the line returns low.
- R3: `cpuIrq` is high one cycle after (pending AND mask) is nonzero, and it is low one cycle after that value is zero.
- R4: A write to word 0x01 clears each pending bit where the written data holds a one. Bits written with zero keep their value.
- R5: When an acknowledge write hits a line whose synchronised level is still high, that line's pending bit stays set. A held level, or a new assertion in the same cycle, wins over the clear.
- R6: A write to word 0x00 replaces all 32 mask bits, and a later read of word 0x00 returns the written value.
- R7: Word 0x02 returns the synchronised line levels. Writes to word 0x02, to the counter words and to unmapped words change no readable state.
- R8: The counter of line n (word 0x20 + n) increases by exactly one for each low-to-high transition of the synchronised line. Holding a line high adds nothing more.
- R9: A read of an unmapped word (0x03 to 0x1F) returns zero. Read data appears on `rdData` on the clock edge that follows the read strobe.
- R10: A line change applied just before clock edge 1 reaches the pending register on edge 3 and reaches `cpuIrq` on edge 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqLines | input | 32 | Asynchronous level interrupt lines, active high |
| regAddr | input | 6 | Word address for register access |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| cpuIrq | output | 1 | Registered interrupt request to the CPU |

## Verification
Most state errors in this block show up at the ports quickly. A pending or mask bit that is set or cleared wrongly changes `cpuIrq` on the next cycle if the other register's matching bit is set. It also shows on the pending or mask read one cycle after the read strobe. A counter that steps wrongly stays hidden until software reads it, so the bench reads counters after known numbers of rising edges. An acknowledge that overrides a held line shows as a pending bit missing on the very next read.

// File: rtl/sticky_irq_pkg.sv
package sticky_irq_pkg;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_MASK = 3'd1,
    SEL_PEND = 3'd2,
    SEL_LINE = 3'd3,
    SEL_CNT  = 3'd4
  } rdSel_e;

  typedef struct packed {
    logic   wrMask;
    logic   wrAck;
    logic   rdEn;
    rdSel_e rdSel;
  } ctlStrobe_t;

  localparam int unsigned WORD_MASK = 0;
  localparam int unsigned WORD_PEND = 1;
  localparam int unsigned WORD_LINE = 2;

endpackage

// File: rtl/sticky_irq_sync.sv
module sticky_irq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stageQ[s] <= '0;
      end else begin
        stageQ[s] <= (s == 0) ? asyncIn : stageQ[(s == 0) ? 0 : s - 1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/sticky_irq_ctl.sv
module sticky_irq_ctl
  import sticky_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned CNT_BASE  = 32,
  localparam int unsigned IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  output ctlStrobe_t        strb,
  output logic [IDX_W-1:0]  cntIdx
);

  logic isMask, isPend, isLine, isCnt;

  always_comb begin
    isMask = (int'(regAddr) == WORD_MASK);
    isPend = (int'(regAddr) == WORD_PEND);
    isLine = (int'(regAddr) == WORD_LINE);
    isCnt  = (int'(regAddr) >= CNT_BASE) && (int'(regAddr) < CNT_BASE + NUM_LINES);
    cntIdx = IDX_W'(int'(regAddr) - CNT_BASE);
  end

  always_comb begin
    strb.wrMask = wrEn & isMask;
    strb.wrAck  = wrEn & isPend;
    strb.rdEn   = rdEn;
    if (isMask)      strb.rdSel = SEL_MASK;
    else if (isPend) strb.rdSel = SEL_PEND;
    else if (isLine) strb.rdSel = SEL_LINE;
    else if (isCnt)  strb.rdSel = SEL_CNT;
    else             strb.rdSel = SEL_NONE;
  end

  // R7: a write reaches at most one writable register
  p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.wrMask, strb.wrAck}));

  // R7: counter and unmapped words never produce a write strobe
  p_ro_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && (strb.rdSel == SEL_CNT || strb.rdSel == SEL_LINE || strb.rdSel == SEL_NONE))
      |-> !(strb.wrMask || strb.wrAck));

endmodule

// File: rtl/sticky_irq_dp.sv
module sticky_irq_dp
  import sticky_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 32,
  localparam int unsigned IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lineSync,
  input  ctlStrobe_t           strb,
  input  logic [IDX_W-1:0]     cntIdx,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic                 cpuIrq
);

  logic [NUM_LINES-1:0] lineState;
  logic [NUM_LINES-1:0] maskQ;
  logic [NUM_LINES-1:0] pendQ;
  logic [NUM_LINES-1:0] ackBits;
  logic [NUM_LINES-1:0] riseBits;
  logic [NUM_LINES-1:0] pendNext;
  logic [CNT_W-1:0]     cntQ [NUM_LINES];
  logic [DATA_W-1:0]    rdQ;
  logic [DATA_W-1:0]    rdNext;
  logic                 irqQ;

  always_comb begin
    ackBits  = strb.wrAck ? wrData[NUM_LINES-1:0] : '0;
    riseBits = lineSync & ~lineState;
    pendNext = (pendQ & ~ackBits) | lineSync;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lineState <= '0;
      maskQ     <= '0;
      pendQ     <= '0;
      irqQ      <= 1'b0;
    end else begin
      lineState <= lineSync;
      pendQ     <= pendNext;
      irqQ      <= |(pendQ & maskQ);
      if (strb.wrMask) maskQ <= wrData[NUM_LINES-1:0];
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cntQ[g] <= '0;
      end else if (riseBits[g]) begin
        cntQ[g] <= cntQ[g] + 1'b1;
      end
    end

    // R8: each counter steps by exactly the number of rises seen
    p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cntQ[g] - $past(cntQ[g])) == CNT_W'($past(riseBits[g]))));
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_MASK: rdNext = DATA_W'(maskQ);
      SEL_PEND: rdNext = DATA_W'(pendQ);
      SEL_LINE: rdNext = DATA_W'(lineState);
      SEL_CNT:  rdNext = DATA_W'(cntQ[cntIdx]);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdQ <= '0;
    end else if (strb.rdEn) begin
      rdQ <= rdNext;
    end
  end

  assign rdData = rdQ;
  assign cpuIrq = irqQ;

  // R2: without an acknowledge no pending bit falls
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrAck |=> ((pendQ & $past(pendQ)) == $past(pendQ)));

  // R3: request follows the masked pending set one cycle later
  p_irq_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpuIrq == |($past(pendQ & maskQ))));

  // R4: acked bits whose line is low are gone after the write
  p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrAck |=> ((pendQ & $past(wrData[NUM_LINES-1:0] & ~lineSync)) == '0));

  // R5: an active synchronised level is always pending next cycle
  p_level_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pendQ & $past(lineSync)) == $past(lineSync)));

  // R6: a mask write lands in full
  p_mask_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrMask |=> (maskQ == $past(wrData[NUM_LINES-1:0])));

  // R7: mask holds when not written
  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrMask |=> $stable(maskQ));

endmodule

// File: rtl/sticky_irq_ctrl.sv
module sticky_irq_ctrl
  import sticky_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned CNT_BASE   = 32,
  parameter int unsigned SYNC_DEPTH = 2,
  localparam int unsigned IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic                 cpuIrq
);

  logic [NUM_LINES-1:0] lineSync;
  ctlStrobe_t           strb;
  logic [IDX_W-1:0]     cntIdx;

  sticky_irq_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_DEPTH)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn (irqLines),
    .syncOut (lineSync)
  );

  sticky_irq_ctl #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W),
    .CNT_BASE  (CNT_BASE)
  ) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .regAddr (regAddr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .strb    (strb),
    .cntIdx  (cntIdx)
  );

  sticky_irq_dp #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .lineSync (lineSync),
    .strb     (strb),
    .cntIdx   (cntIdx),
    .wrData   (wrData),
    .rdData   (rdData),
    .cpuIrq   (cpuIrq)
  );

endmodule

// File: tb/tb_sticky_irq_ctrl.sv
module tb_sticky_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irqLines = '0;
  logic [5:0]  regAddr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        cpuIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int expCnt [32];

  always #5 clk = ~clk;

  sticky_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irqLines(irqLines), .regAddr(regAddr),
    .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .cpuIrq(cpuIrq)
  );

  typedef struct packed {
    logic [31:0] lines;
    logic [31:0] mask;
    logic        expIrq;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0001, 32'h0000_0001, 1'b1},
    '{32'h8000_0000, 32'h7fff_ffff, 1'b0},
    '{32'h00f0_0000, 32'h0010_0000, 1'b1},
    '{32'h0000_0000, 32'hffff_ffff, 1'b0},
    '{32'ha5a5_a5a5, 32'h5a5a_5a5a, 1'b0},
    '{32'hffff_ffff, 32'h8000_0000, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    regAddr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic setLines(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i] && !irqLines[i]) expCnt[i]++;
    irqLines = v;
  endtask

  task automatic clearAll();
    setLines('0);
    cyc(4);
    wr(6'h00, 32'h0);
    wr(6'h01, 32'hffff_ffff);
    cyc(2);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 32; i++) expCnt[i] = 0;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 irq", {31'b0, cpuIrq}, 32'h0);
    rd(6'h00, d); check("R1 mask", d, 32'h0);
    rd(6'h01, d); check("R1 pend", d, 32'h0);
    rd(6'h02, d); check("R1 line", d, 32'h0);
    rd(6'h20, d); check("R1 cnt0", d, 32'h0);
    rd(6'h3f, d); check("R1 cnt31", d, 32'h0);

    // R2/R3/R6: vector walk
    for (int v = 0; v < NVEC; v++) begin
      clearAll();
      setLines(VECS[v].lines);
      cyc(3);
      setLines('0);
      cyc(4);
      wr(6'h00, VECS[v].mask);
      cyc(2);
      check("R3 irq vector", {31'b0, cpuIrq}, {31'b0, VECS[v].expIrq});
      check("R3 irq model", {31'b0, cpuIrq}, {31'b0, |(VECS[v].lines & VECS[v].mask)});
      rd(6'h01, d); check("R2 sticky pend", d, VECS[v].lines);
      rd(6'h00, d); check("R6 mask readback", d, VECS[v].mask);
    end

    // R8/R9: counters after vector walk
    foreach (expCnt[i]) begin
      if (i % 5 == 0 || i == 31) begin
        rd(6'(32 + i), d); check("R8 counter", d, 32'(expCnt[i]));
      end
    end

    // R10: latency of line to request
    clearAll();
    wr(6'h00, 32'h0000_0080);
    setLines(32'h0000_0080);
    cyc(3);
    check("R10 irq low at edge 3", {31'b0, cpuIrq}, 32'h0);
    cyc(1);
    check("R10 irq high at edge 4", {31'b0, cpuIrq}, 32'h1);

    // R5: ack while line held keeps pending and request
    wr(6'h01, 32'hffff_ffff);
    rd(6'h01, d); check("R5 held line survives ack", d, 32'h0000_0080);
    cyc(1);
    check("R5 irq stays", {31'b0, cpuIrq}, 32'h1);
    // R7: line state readback
    rd(6'h02, d); check("R7 line state", d, 32'h0000_0080);
    // R8: held line counted once
    cyc(10);
    rd(6'h27, d); check("R8 held counted once", d, 32'(expCnt[7]));
    setLines('0);
    cyc(4);
    wr(6'h01, 32'h0000_0080);
    rd(6'h01, d); check("R4 ack after drop", d, 32'h0);
    cyc(1);
    check("R3 irq falls", {31'b0, cpuIrq}, 32'h0);

    // R4: partial ack
    clearAll();
    setLines(32'h0000_000f);
    cyc(3);
    setLines('0);
    cyc(4);
    wr(6'h01, 32'h0000_0005);
    rd(6'h01, d); check("R4 partial ack", d, 32'h0000_000a);

    // R7: writes to read-only words ignored
    wr(6'h02, 32'hffff_ffff);
    rd(6'h02, d); check("R7 line write ignored", d, 32'h0);
    wr(6'h21, 32'h1234_5678);
    rd(6'h21, d); check("R7 counter write ignored", d, 32'(expCnt[1]));
    wr(6'h05, 32'hffff_ffff);
    rd(6'h00, d); check("R7 unmapped write mask", d, 32'h0);
    rd(6'h01, d); check("R7 unmapped write pend", d, 32'h0000_000a);
    // R9: unmapped read
    rd(6'h05, d); check("R9 unmapped read", d, 32'h0);
    rd(6'h1f, d); check("R9 unmapped read top", d, 32'h0);

    // R1: reset after activity
    wr(6'h00, 32'hffff_ffff);
    cyc(2);
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", {31'b0, cpuIrq}, 32'h0);
    rd(6'h00, d); check("R1 mask after reset", d, 32'h0);
    rd(6'h01, d); check("R1 pend after reset", d, 32'h0);
    rd(6'h20, d); check("R1 cnt after reset", d, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end

endmodule